// File: doc/BRIEF.md
# Compare Timer With Sticky Match Flags

This block is a register-mapped timer. A counter runs from a base tick enable through a power-of-two prescaler. Its counting width can be chosen at run time. Four compare slots each own a sticky match flag. Software starts, halts and zeroes the counter by writing one-shot command words. It then reads or clears the match flags over the same register port. Each flag is also driven as a level on its own output pin.

A match is raised when a counting step moves the counter onto a slot's compare value. Because the counter advances by one per step, every value it passes is also landed on. A compare value that lies behind the current count is therefore seen only after the counter wraps at the chosen width and climbs back up to it. The flag stays set until software clears it.

Top module: `timer_cmp_evt`

## Requirements
- R1: After reset the counter is stopped at zero, all flags are 0, the width code reads 0, the prescale reads 0 and every compare slot reads 0.
- R2: Writing a word with bit 0 set to the start word (word 0) makes the counter run, and writing it to the halt word (word 1) stops it with its count held and no flags raised. A command write with bit 0 clear has no effect.
- R3: Writing bit 0 set to the zero word (word 2) sets the count and the prescale divider to 0.
- R4: While running, the counter takes one step every 2^P asserted base ticks, where P is the prescale at word 5. A written value above 9 is stored and read back as 9.
- R5: The width code at word 4 selects the counter width: 0 gives 16 bits, 1 gives 8 bits, 2 gives 24 bits and 3 gives 32 bits. The counter wraps from all ones to 0 at that width, and the compare uses only the low bits of that width.
- R6: When a step brings the count equal to the compare value of slot i (word 8+i), flag i is set. It then stays set through any later steps.
- R7: Writing 0 to the flag word of slot i (word 16+i) clears flag i. Writing a nonzero value there has no effect.
- R8: A compare value written after the counter has passed it raises its flag only after the counter wraps and steps up to it again.
- R9: When a command write and a step fall in the same cycle, the compare uses the count from before the command. A zero command in that cycle still sets the count to 0.
- R10: When a match and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R11: Reads of words 4, 5, 8+i and 16+i return the stored width code, prescale, full compare value and flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick enable that feeds the prescaler |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed word (combinational) |
| evt_o | output | NUM_CC | Match flag levels, one per compare slot |

## Verification
The bench builds the block with its default parameters: four compare slots, a 32-bit counter and a prescale capped at 9. The 8-bit width puts a wrap within 256 steps, so both the late-compare case and the randomized runs cover wraps. The 16-bit width is exercised with one full wrap of 65536 steps at prescale 0. Randomized runs draw prescales from 0 to 3 and mix all four widths, which covers the divider across several rates. The cap at 9 is checked by a direct read-back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CNT_W = 32;

    typedef enum logic [1:0] {
        WM_16 = 2'd0,
        WM_8  = 2'd1,
        WM_24 = 2'd2,
        WM_32 = 2'd3
    } width_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
    } core_state_t;

    function automatic logic [CNT_W-1:0] width_mask(width_mode_e m);
        logic [CNT_W-1:0] ones;
        ones = '1;
        case (m)
            WM_8:    return ones >> (CNT_W - 8);
            WM_16:   return ones >> (CNT_W - 16);
            WM_24:   return ones >> (CNT_W - 24);
            default: return ones;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned PRE_MAX = 9,
    parameter int unsigned PRE_W   = $clog2(PRE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             adv_o
);
    localparam int unsigned DIV_W = (PRE_MAX > 0) ? PRE_MAX : 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] div_mask;

    always_comb begin
        div_mask = (DIV_W'(1) << pre_i) - DIV_W'(1);
        adv_o    = tick_i && run_i && ((div_q & div_mask) == div_mask);
        div_d    = div_q;
        if (clr_i) begin
            div_d = '0;
        end else if (tick_i && run_i) begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // R3: a zero command restarts the divider
    p_div_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> div_q == '0);

    // R2: no step while the counter is halted
    p_no_step_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !adv_o);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             running_o,
    output logic [CNT_W-1:0] step_val_o
);
    core_state_t st_d, st_q;

    always_comb begin
        step_val_o    = (st_q.count + CNT_W'(1)) & mask_i;
        st_d          = st_q;
        st_d.count    = st_q.count & mask_i;
        if (adv_i) begin
            st_d.count = step_val_o;
        end
        if (clr_i) begin
            st_d.count = '0;
        end
        if (start_i) begin
            st_d.running = 1'b1;
        end
        if (stop_i) begin
            st_d.running = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o = st_q.running;

    // R2: steps arrive only while running
    p_step_when_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> st_q.running);

    // R3: zero command lands the count on zero
    p_count_zeroed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.count == '0);

    // R5: count never holds bits above the active width
    p_in_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.count & ~$past(mask_i)) == '0);

endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CC = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv_i,
    input  logic [CNT_W-1:0]             step_val_i,
    input  logic [CNT_W-1:0]             mask_i,
    input  logic [NUM_CC-1:0][CNT_W-1:0] cc_i,
    input  logic [NUM_CC-1:0]            clr_i,
    output logic [NUM_CC-1:0]            evt_o
);
    logic [NUM_CC-1:0] hit;
    logic [NUM_CC-1:0] evt_d, evt_q;

    for (genvar g = 0; g < NUM_CC; g++) begin : g_slot
        assign hit[g] = adv_i && ((cc_i[g] & mask_i) == step_val_i);

        // R6: a set flag survives until software clears it
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_q[g] && !clr_i[g] |=> evt_q[g]);

        // R6: a flag only rises in a cycle after a step
        p_rise_on_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_q[g]) |-> $past(adv_i));

        // R10: match beats software clear
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] && clr_i[g] |=> evt_q[g]);
    end

    always_comb begin
        evt_d = hit | (evt_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/timer_cmp_evt.sv
module timer_cmp_evt
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CC  = 4,
    parameter int unsigned PRE_MAX = 9,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CC-1:0] evt_o
);
    localparam int unsigned PRE_W      = $clog2(PRE_MAX + 1);
    localparam int unsigned A_START    = 0;
    localparam int unsigned A_STOP     = 1;
    localparam int unsigned A_ZERO     = 2;
    localparam int unsigned A_WIDTH    = 4;
    localparam int unsigned A_PRESC    = 5;
    localparam int unsigned A_CC_BASE  = 8;
    localparam int unsigned A_EVT_BASE = 16;

    typedef struct packed {
        width_mode_e                  mode;
        logic [PRE_W-1:0]             pre;
        logic [NUM_CC-1:0][CNT_W-1:0] cc;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic              wr;
    logic              cmd_start, cmd_stop, cmd_zero;
    logic [NUM_CC-1:0] evt_clr;
    logic [CNT_W-1:0]  mask;
    logic              adv;
    logic              running;
    logic [CNT_W-1:0]  step_val;

    always_comb begin
        wr        = bus_sel_i && bus_we_i;
        cmd_start = wr && (bus_addr_i == ADDR_W'(A_START)) && bus_wdata_i[0];
        cmd_stop  = wr && (bus_addr_i == ADDR_W'(A_STOP))  && bus_wdata_i[0];
        cmd_zero  = wr && (bus_addr_i == ADDR_W'(A_ZERO))  && bus_wdata_i[0];
        cfg_d     = cfg_q;
        if (wr && bus_addr_i == ADDR_W'(A_WIDTH)) begin
            cfg_d.mode = width_mode_e'(bus_wdata_i[1:0]);
        end
        if (wr && bus_addr_i == ADDR_W'(A_PRESC)) begin
            if (bus_wdata_i > DATA_W'(PRE_MAX)) begin
                cfg_d.pre = PRE_W'(PRE_MAX);
            end else begin
                cfg_d.pre = bus_wdata_i[PRE_W-1:0];
            end
        end
        for (int i = 0; i < NUM_CC; i++) begin
            if (wr && bus_addr_i == ADDR_W'(A_CC_BASE + i)) begin
                cfg_d.cc[i] = bus_wdata_i[CNT_W-1:0];
            end
            evt_clr[i] = wr && (bus_addr_i == ADDR_W'(A_EVT_BASE + i))
                         && (bus_wdata_i == '0);
        end
        mask = width_mask(cfg_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(A_WIDTH)) begin
            bus_rdata_o = DATA_W'(cfg_q.mode);
        end
        if (bus_addr_i == ADDR_W'(A_PRESC)) begin
            bus_rdata_o = DATA_W'(cfg_q.pre);
        end
        for (int i = 0; i < NUM_CC; i++) begin
            if (bus_addr_i == ADDR_W'(A_CC_BASE + i)) begin
                bus_rdata_o = DATA_W'(cfg_q.cc[i]);
            end
            if (bus_addr_i == ADDR_W'(A_EVT_BASE + i)) begin
                bus_rdata_o = DATA_W'(evt_o[i]);
            end
        end
    end

    tmr_prescale #(
        .PRE_MAX (PRE_MAX),
        .PRE_W   (PRE_W)
    ) prescale_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (running),
        .clr_i  (cmd_zero),
        .pre_i  (cfg_q.pre),
        .adv_o  (adv)
    );

    tmr_core core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .start_i    (cmd_start),
        .stop_i     (cmd_stop),
        .clr_i      (cmd_zero),
        .mask_i     (mask),
        .running_o  (running),
        .step_val_o (step_val)
    );

    tmr_cmp_bank #(
        .NUM_CC (NUM_CC)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .step_val_i (step_val),
        .mask_i     (mask),
        .cc_i       (cfg_q.cc),
        .clr_i      (evt_clr),
        .evt_o      (evt_o)
    );

    // R4: stored prescale never exceeds its cap
    p_pre_capped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.pre <= PRE_W'(PRE_MAX));

    // R7: a nonzero write to a flag word leaves a set flag alone
    p_nonzero_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr_i == ADDR_W'(A_EVT_BASE) && bus_wdata_i != '0 && evt_o[0]
        |=> evt_o[0]);

endmodule

// File: tb/timer_cmp_evt_tb_top.sv
module timer_cmp_evt_tb_top;
    localparam int unsigned NCC = 4;
    localparam int unsigned AW  = 5;
    localparam int unsigned DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCC-1:0] evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    timer_cmp_evt dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .evt_o       (evt)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd_reg(int a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = AW'(a);
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic run_ticks(int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    // one step landing in the same cycle as a register write
    task automatic tick_with_wr(int a, logic [31:0] d);
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0; we = 1'b0;
    endtask

    function automatic bit exp_hit(logic [31:0] cc, longint steps, int bits);
        longint span = longint'(1) << bits;
        longint v    = longint'(cc) & (span - 1);
        if (steps >= span) return 1'b1;
        return (v >= 1) && (v <= steps);
    endfunction

    function automatic int mode_bits(int m);
        case (m)
            1: return 8;
            2: return 24;
            3: return 32;
            default: return 16;
        endcase
    endfunction

    task automatic fresh(int mode);
        wr_reg(1, 1);
        wr_reg(4, 32'(mode));
        wr_reg(2, 1);
        for (int i = 0; i < NCC; i++) wr_reg(16 + i, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 flags", 32'(evt), 0);
        rd_reg(4, r);  chk("R1 width", r, 0);
        rd_reg(5, r);  chk("R1 prescale", r, 0);
        rd_reg(8, r);  chk("R1 cc0", r, 0);
        rd_reg(16, r); chk("R1 flag0 word", r, 0);

        // R2 start / halt, R6 sticky, R7 clear
        wr_reg(4, 1);
        rd_reg(4, r);  chk("R11 width readback", r, 1);
        wr_reg(8, 5);
        wr_reg(2, 1);
        wr_reg(0, 1);
        run_ticks(4);   chk("R2 before match", 32'(evt[0]), 0);
        wr_reg(1, 1);
        run_ticks(10);  chk("R2 halted holds", 32'(evt[0]), 0);
        wr_reg(0, 1);
        run_ticks(1);   chk("R6 match sets", 32'(evt[0]), 1);
        run_ticks(20);  chk("R6 sticky", 32'(evt[0]), 1);
        rd_reg(16, r);  chk("R11 flag word", r, 1);
        wr_reg(16, 7);  #1 chk("R7 nonzero ignored", 32'(evt[0]), 1);
        wr_reg(16, 0);  #1 chk("R7 zero clears", 32'(evt[0]), 0);

        // R2 command with bit 0 clear ignored
        wr_reg(1, 1);
        wr_reg(0, 0);
        run_ticks(300); chk("R2 zero-data start ignored", 32'(evt), 0);

        // R3 zero command
        wr_reg(2, 1);
        wr_reg(8, 3);
        wr_reg(0, 1);
        run_ticks(2);   chk("R3 after zero, short", 32'(evt[0]), 0);
        run_ticks(1);   chk("R3 after zero, hit", 32'(evt[0]), 1);

        // R4 prescale 2 -> step every 4 ticks
        fresh(1);
        wr_reg(5, 2);
        wr_reg(8, 3);
        wr_reg(0, 1);
        run_ticks(11);  chk("R4 prescale short", 32'(evt[0]), 0);
        run_ticks(1);   chk("R4 prescale hit", 32'(evt[0]), 1);
        wr_reg(5, 15);
        rd_reg(5, r);   chk("R4 cap", r, 9);
        wr_reg(5, 0);

        // R5 compare on active width only
        fresh(1);
        wr_reg(8, 32'h105);
        wr_reg(0, 1);
        run_ticks(5);   chk("R5 masked compare", 32'(evt[0]), 1);
        rd_reg(8, r);   chk("R11 cc full value", r, 32'h105);

        // R8 late compare in 8-bit mode
        fresh(1);
        wr_reg(8, 0);
        wr_reg(0, 1);
        run_ticks(100);
        wr_reg(16, 0);
        wr_reg(8, 50);
        run_ticks(155); chk("R8 before wrap", 32'(evt[0]), 0);
        run_ticks(1);   chk("R8 at wrap", 32'(evt[0]), 0);
        run_ticks(49);  chk("R8 one short", 32'(evt[0]), 0);
        run_ticks(1);   chk("R8 after wrap hit", 32'(evt[0]), 1);

        // R9 zero command with a step in the same cycle
        fresh(1);
        wr_reg(8, 5);
        wr_reg(0, 1);
        run_ticks(4);
        tick_with_wr(2, 1);
        #1 chk("R9 pre-command compare", 32'(evt[0]), 1);
        wr_reg(16, 0);
        run_ticks(4);   chk("R9 count restarted", 32'(evt[0]), 0);
        run_ticks(1);   chk("R9 second hit", 32'(evt[0]), 1);

        // R10 match beats clear
        fresh(1);
        wr_reg(9, 5);
        wr_reg(0, 1);
        run_ticks(4);
        tick_with_wr(17, 0);
        #1 chk("R10 set wins", 32'(evt[1]), 1);

        // R5/R8 16-bit wrap
        fresh(0);
        wr_reg(10, 0);
        wr_reg(0, 1);
        run_ticks(10);
        wr_reg(18, 0);
        wr_reg(10, 3);
        run_ticks(65525); chk("R5 16-bit top", 32'(evt[2]), 0);
        run_ticks(1);     chk("R5 16-bit wrap", 32'(evt[2]), 0);
        run_ticks(3);     chk("R8 16-bit late hit", 32'(evt[2]), 1);

        // randomized runs, R6 with R4/R5
        for (int t = 0; t < 40; t++) begin
            int mode = $urandom_range(0, 3);
            int pre  = $urandom_range(0, 3);
            int nt   = $urandom_range(0, 600);
            logic [31:0] ccv [NCC];
            fresh(mode);
            wr_reg(5, 32'(pre));
            for (int i = 0; i < NCC; i++) begin
                ccv[i] = 32'($urandom_range(0, 300));
                wr_reg(8 + i, ccv[i]);
            end
            wr_reg(0, 1);
            run_ticks(nt);
            for (int i = 0; i < NCC; i++) begin
                chk($sformatf("R6 random t%0d slot%0d", t, i), 32'(evt[i]),
                    32'(exp_hit(ccv[i], longint'(nt >> pre), mode_bits(mode))));
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule